// File: doc/BRIEF.md
# Receive FIFO Status and Interrupt Generator

This block keeps the occupancy bookkeeping for a small receive FIFO that a serial shift engine fills and a processor or DMA engine drains. The storage array lives elsewhere. This block tracks how many words are held and says whether an arriving word may be written (`word_accept`). It derives not-empty, full and overrun flags from that count. When a word completes while the FIFO is already full, the word is dropped and an overrun is latched.

A two-bit enable field, written through a small register port, picks the receive condition that raises an interrupt request: not-empty or full. An overrun always raises the request and takes priority, and a vector-select output marks the overrun case. When software turns interrupts off by writing zero to the field, the old setting keeps gating the request for one more cycle. Three reset sources are present. The hardware reset is asynchronous. The software reset and the module-local reset are synchronous. A stop-state input holds the flags clear and ignores traffic while it is high.

Top module: `rx_fifo_status`

## Requirements
- R1: After hardware reset, `fill_level`, `not_empty`, `full`, `overrun`, `irq_req` and `irq_ovr_vec` are 0, and the enable field reads 00.
- R2: `not_empty` is 1 exactly when at least one word is held. A read that leaves zero words clears it. A read of an empty FIFO changes nothing.
- R3: `full` is 1 exactly when `DEPTH` words are held. A read at full clears it on the next cycle.
- R4: A `word_done` pulse while `full` is 1 sets `overrun`, drops the word (`word_accept` low, `fill_level` unchanged unless a read pops in the same cycle), and keeps `full`.
- R5: `overrun` clears only on a `fifo_rd` that comes after a `stat_rd` seen while `overrun` was set. A `fifo_rd` without that earlier status read leaves `overrun` at 1.
- R6: With the enable field at 00 (disabled) or 10 (reserved), `irq_req` stays 0 whatever the flags are.
- R7: With the field at 01, `irq_req` equals `not_empty | overrun`. With the field at 11, `irq_req` equals `full | overrun`.
- R8: `irq_ovr_vec` is 1 exactly when `irq_req` is 1 and `overrun` is 1.
- R9: After a write of 00 to the field, the earlier non-zero mode still gates `irq_req` for one cycle. The request drops one cycle later.
- R10: `soft_rst` clears the enable field and all flags. `local_rst` clears the flags and the count but keeps the enable field.
- R11: `stat_word` carries `not_empty` in bit 0, `full` in bit 1, `overrun` in bit 2 and the enable field in bits 4:3. Every other bit reads 0.
- R12: While `stop_mode` is 1, the count and the flags are held at 0, and `word_done` and `fifo_rd` are ignored (`word_accept` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| local_rst | input | 1 | Synchronous module-local reset (flags only) |
| stop_mode | input | 1 | Stop state: flags held clear, strobes ignored |
| word_done | input | 1 | Single-cycle pulse: the shift engine completed a word |
| fifo_rd | input | 1 | Single-cycle pulse: CPU/DMA read of the FIFO |
| stat_rd | input | 1 | Single-cycle pulse: status register read |
| ien_wr | input | 1 | Write strobe for the enable field |
| ien_wdata | input | 2 | Enable field value (00 off, 01 not-empty, 10 reserved, 11 full) |
| word_accept | output | 1 | The completed word may be written into storage |
| fill_level | output | CNT_W | Number of words held |
| not_empty | output | 1 | At least one word held |
| full | output | 1 | DEPTH words held |
| overrun | output | 1 | A word was dropped because the FIFO was full |
| irq_req | output | 1 | Receive interrupt request |
| irq_ovr_vec | output | 1 | Vector select: the request is for an overrun |
| stat_word | output | STAT_W | Status readback image |

## Verification
The assertions watch, on every cycle, the rules that hold at each clock edge: full implies not-empty, a word that arrives at full is dropped and sets overrun, overrun does not clear without a read, reserved mode stays silent, mode 01 follows its flags, the vector select agrees with the request, the delayed mask keeps the request alive for one cycle, the local reset keeps the enable field, and the stop state clears the flags. Some properties depend on an ordering of events over several cycles or on a full sweep of fill levels. These are the exact occupancy for every mode, the status-read-then-FIFO-read order that clears overrun, the drop of the request one cycle after the delayed mask, and the difference between the software and the local reset. Only the bench's scenarios show them, by comparing against a cycle model built from the requirements.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic [1:0] {
    IEN_OFF      = 2'b00,
    IEN_NONEMPTY = 2'b01,
    IEN_RSVD     = 2'b10,
    IEN_FULL     = 2'b11
  } ien_mode_e;

  // status word bit positions
  localparam int unsigned ST_NE     = 0;
  localparam int unsigned ST_FULL   = 1;
  localparam int unsigned ST_OVR    = 2;
  localparam int unsigned ST_IEN_LO = 3;
  localparam int unsigned ST_USED   = 5;

  // A zero write keeps the previous mode active for one more cycle.
  function automatic ien_mode_e effective_mode(input ien_mode_e cur, input ien_mode_e prev);
    return (cur == IEN_OFF) ? prev : cur;
  endfunction

  // Overrun always requests; the data condition depends on the mode.
  function automatic logic request_for(input ien_mode_e m, input logic ne, input logic fl,
                                       input logic ovr);
    case (m)
      IEN_NONEMPTY: return ovr | ne;
      IEN_FULL:     return ovr | fl;
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rxs_occupancy.sv
module rxs_occupancy #(
  parameter int DEPTH = 10,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             word_done,
  input  logic             fifo_rd,
  output logic [CNT_W-1:0] count,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             not_empty,
  output logic             full
);

  localparam logic [CNT_W-1:0] TOP = CNT_W'(DEPTH);

  function automatic logic [CNT_W-1:0] next_fill(input logic [CNT_W-1:0] c,
                                                  input logic inc, input logic dec);
    case ({inc, dec})
      2'b10:   return c + CNT_W'(1);
      2'b01:   return c - CNT_W'(1);
      default: return c;
    endcase
  endfunction

  assign not_empty = (count != '0);
  assign full      = (count == TOP);
  assign push_ok   = word_done & ~full & ~flush;
  assign pop_ok    = fifo_rd & not_empty & ~flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (flush) count <= '0;
    else            count <= next_fill(count, push_ok, pop_ok);
  end

endmodule

// File: rtl/rxs_overrun.sv
module rxs_overrun (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic set_evt,
  input  logic stat_rd,
  input  logic fifo_rd,
  output logic overrun,
  output logic armed,
  output logic clr_evt
);

  assign clr_evt = fifo_rd & armed & ~flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun <= 1'b0;
      armed   <= 1'b0;
    end else if (flush) begin
      overrun <= 1'b0;
      armed   <= 1'b0;
    end else begin
      overrun <= set_evt | (overrun & ~clr_evt);
      if (clr_evt)                armed <= 1'b0;
      else if (stat_rd & overrun) armed <= 1'b1;
    end
  end

endmodule

// File: rtl/rxs_irq_ctrl.sv
module rxs_irq_ctrl
  import rxs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      soft_rst,
  input  logic      ien_wr,
  input  logic [1:0] ien_wdata,
  input  logic      not_empty,
  input  logic      full,
  input  logic      overrun,
  output ien_mode_e ien_cur,
  output ien_mode_e ien_prev,
  output ien_mode_e mode_eff,
  output logic      irq_req,
  output logic      irq_ovr_vec
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_cur  <= IEN_OFF;
      ien_prev <= IEN_OFF;
    end else if (soft_rst) begin
      ien_cur  <= IEN_OFF;
      ien_prev <= IEN_OFF;
    end else begin
      ien_prev <= ien_cur;
      if (ien_wr) ien_cur <= ien_mode_e'(ien_wdata);
    end
  end

  assign mode_eff    = effective_mode(ien_cur, ien_prev);
  assign irq_req     = request_for(mode_eff, not_empty, full, overrun);
  assign irq_ovr_vec = irq_req & overrun;

endmodule

// File: rtl/rx_fifo_status.sv
module rx_fifo_status
  import rxs_pkg::*;
#(
  parameter int DEPTH  = 10,
  parameter int STAT_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              local_rst,
  input  logic              stop_mode,
  input  logic              word_done,
  input  logic              fifo_rd,
  input  logic              stat_rd,
  input  logic              ien_wr,
  input  logic [1:0]        ien_wdata,
  output logic              word_accept,
  output logic [CNT_W-1:0]  fill_level,
  output logic              not_empty,
  output logic              full,
  output logic              overrun,
  output logic              irq_req,
  output logic              irq_ovr_vec,
  output logic [STAT_W-1:0] stat_word
);

  // named internal events
  logic      flush;
  logic      pop_ok;
  logic      ovr_set_evt;
  logic      ovr_clr_evt;
  logic      ovr_armed;
  ien_mode_e ien_cur;
  ien_mode_e ien_prev;
  ien_mode_e mode_eff;

  assign flush = soft_rst | local_rst | stop_mode;

  rxs_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .word_done (word_done),
    .fifo_rd   (fifo_rd),
    .count     (fill_level),
    .push_ok   (word_accept),
    .pop_ok    (pop_ok),
    .not_empty (not_empty),
    .full      (full)
  );

  assign ovr_set_evt = word_done & full & ~flush;

  rxs_overrun u_ovr (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .set_evt (ovr_set_evt),
    .stat_rd (stat_rd),
    .fifo_rd (fifo_rd),
    .overrun (overrun),
    .armed   (ovr_armed),
    .clr_evt (ovr_clr_evt)
  );

  rxs_irq_ctrl u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .ien_wr      (ien_wr),
    .ien_wdata   (ien_wdata),
    .not_empty   (not_empty),
    .full        (full),
    .overrun     (overrun),
    .ien_cur     (ien_cur),
    .ien_prev    (ien_prev),
    .mode_eff    (mode_eff),
    .irq_req     (irq_req),
    .irq_ovr_vec (irq_ovr_vec)
  );

  always_comb begin
    stat_word                   = '0;
    stat_word[ST_NE]            = not_empty;
    stat_word[ST_FULL]          = full;
    stat_word[ST_OVR]           = overrun;
    stat_word[ST_IEN_LO +: 2]   = ien_cur;
  end

endmodule

// File: rtl/rx_fifo_status_chk.sv
module rx_fifo_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       local_rst,
  input logic       stop_mode,
  input logic       word_done,
  input logic       fifo_rd,
  input logic       ien_wr,
  input logic [1:0] ien_wdata,
  input logic       not_empty,
  input logic       full,
  input logic       overrun,
  input logic       irq_req,
  input logic       irq_ovr_vec,
  input logic [1:0] ien_q
);

  logic quiet;
  assign quiet = ~soft_rst & ~local_rst & ~stop_mode;

  p_ne_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (not_empty && !fifo_rd && quiet) |=> not_empty);

  p_full_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> not_empty);

  p_drop_at_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && word_done && !fifo_rd && quiet) |=> (full && overrun));

  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !fifo_rd && quiet) |=> overrun);

  p_reserved_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 2'b10) |-> !irq_req);

  p_nonempty_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 2'b01) |-> (irq_req == (not_empty || overrun)));

  p_vector_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovr_vec |-> (irq_req && overrun));

  p_late_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_wr && ien_wdata == 2'b00 && ien_q == 2'b01 && not_empty && !fifo_rd && quiet)
      |=> irq_req);

  p_local_keeps_ien_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (local_rst && !soft_rst && !ien_wr) |=> $stable(ien_q));

  p_stop_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |=> (!not_empty && !overrun));

endmodule

bind rx_fifo_status rx_fifo_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .local_rst   (local_rst),
  .stop_mode   (stop_mode),
  .word_done   (word_done),
  .fifo_rd     (fifo_rd),
  .ien_wr      (ien_wr),
  .ien_wdata   (ien_wdata),
  .not_empty   (not_empty),
  .full        (full),
  .overrun     (overrun),
  .irq_req     (irq_req),
  .irq_ovr_vec (irq_ovr_vec),
  .ien_q       (ien_cur)
);

// File: tb/tb_rx_fifo_status.sv
`timescale 1ns/1ps
module tb_rx_fifo_status;

  localparam int DEPTH  = 10;
  localparam int STAT_W = 8;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n, soft_rst, local_rst, stop_mode;
  logic word_done, fifo_rd, stat_rd, ien_wr;
  logic [1:0] ien_wdata;
  logic word_accept, not_empty, full, overrun, irq_req, irq_ovr_vec;
  logic [CNT_W-1:0] fill_level;
  logic [STAT_W-1:0] stat_word;

  always #2 clk = ~clk;  // 250 MHz

  rx_fifo_status #(.DEPTH(DEPTH), .STAT_W(STAT_W)) dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // cycle model
  int m_cnt = 0;
  bit m_ovr = 0, m_arm = 0;
  int m_ien = 0, m_prev = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    int eff; bit ne, fl, irq;
    eff = (m_ien == 0) ? m_prev : m_ien;
    ne  = (m_cnt > 0);
    fl  = (m_cnt == DEPTH);
    irq = (eff == 1) ? (ne | m_ovr) : (eff == 3) ? (fl | m_ovr) : 1'b0;
    chk(tag, "fill_level R2", int'(fill_level), m_cnt);
    chk(tag, "not_empty R2", int'(not_empty), int'(ne));
    chk(tag, "full R3", int'(full), int'(fl));
    chk(tag, "overrun R4", int'(overrun), int'(m_ovr));
    chk(tag, "irq_req R7", int'(irq_req), int'(irq));
    chk(tag, "irq_ovr_vec R8", int'(irq_ovr_vec), int'(irq & m_ovr));
    chk(tag, "stat_word R11", int'(stat_word),
        int'(ne) + 2 * int'(fl) + 4 * int'(m_ovr) + 8 * m_ien);
  endtask

  task automatic cycle(bit wd, bit rd, bit srd, bit wr, int wdat, bit sr, bit lr, bit st,
                       string tag);
    bit was_full, clr;
    @(negedge clk);
    word_done = wd; fifo_rd = rd; stat_rd = srd; ien_wr = wr; ien_wdata = 2'(wdat);
    soft_rst = sr; local_rst = lr; stop_mode = st;
    #1;
    chk(tag, "word_accept R4", int'(word_accept),
        int'(wd && !sr && !lr && !st && m_cnt < DEPTH));
    @(posedge clk); #1;
    if (sr) begin
      m_cnt = 0; m_ovr = 0; m_arm = 0; m_ien = 0; m_prev = 0;
    end else begin
      m_prev = m_ien;
      if (wr) m_ien = wdat;
      if (lr || st) begin
        m_cnt = 0; m_ovr = 0; m_arm = 0;
      end else begin
        was_full = (m_cnt == DEPTH);
        clr = rd && m_arm;
        if (clr) begin m_ovr = 0; m_arm = 0; end
        else if (srd && m_ovr) m_arm = 1;
        if (wd && was_full) m_ovr = 1;
        if (rd && m_cnt > 0) m_cnt--;
        if (wd && !was_full) m_cnt++;
      end
    end
    compare_all(tag);
    @(negedge clk);
    word_done = 0; fifo_rd = 0; stat_rd = 0; ien_wr = 0;
    soft_rst = 0; local_rst = 0; stop_mode = 0;
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_cnt = 0; m_ovr = 0; m_arm = 0; m_ien = 0; m_prev = 0;
    #1; compare_all("R1 reset");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; soft_rst = 0; local_rst = 0; stop_mode = 0;
    word_done = 0; fifo_rd = 0; stat_rd = 0; ien_wr = 0; ien_wdata = 0;
    hw_reset();

    // sweep every mode over every fill level, overrun and its clearing order
    for (int mode = 0; mode < 4; mode++) begin
      cycle(0,0,0,0,0,1,0,0, "R10 soft reset");
      cycle(0,0,0,1,mode,0,0,0, "R6 R7 mode write");
      for (int k = 0; k < DEPTH + 2; k++) cycle(1,0,0,0,0,0,0,0, "R2 R3 R4 fill");
      cycle(1,1,0,0,0,0,0,0, "R4 push+pop at full");
      cycle(1,0,0,0,0,0,0,0, "R3 refill");
      cycle(0,1,0,0,0,0,0,0, "R5 read without status read");
      chk("R5", "overrun kept", int'(overrun), 1);
      cycle(0,0,1,0,0,0,0,0, "R5 status read");
      cycle(0,1,0,0,0,0,0,0, "R5 clearing read");
      chk("R5", "overrun cleared", int'(overrun), 0);
      for (int k = 0; k < DEPTH + 1; k++) cycle(0,1,0,0,0,0,0,0, "R2 drain");
      chk("R2", "empty after drain", int'(not_empty), 0);
      cycle(0,1,0,0,0,0,0,0, "R2 read empty");
    end

    // delayed mask
    cycle(0,0,0,0,0,1,0,0, "R10 soft reset");
    cycle(0,0,0,1,1,0,0,0, "R9 enable");
    cycle(1,0,0,0,0,0,0,0, "R9 one word");
    chk("R9", "irq before mask", int'(irq_req), 1);
    cycle(0,0,0,1,0,0,0,0, "R9 write 00");
    chk("R9", "irq one cycle after 00 write", int'(irq_req), 1);
    cycle(0,0,0,0,0,0,0,0, "R9 idle");
    chk("R9", "irq masked", int'(irq_req), 0);
    chk("R6", "disabled with data", int'(not_empty), 1);

    // local reset keeps mode, soft reset clears it
    cycle(0,0,0,1,3,0,0,0, "R10 mode 11");
    for (int k = 0; k < DEPTH + 1; k++) cycle(1,0,0,0,0,0,0,0, "R7 full mode fill");
    cycle(0,0,0,0,0,0,1,0, "R10 local reset");
    chk("R10", "mode kept by local reset", int'(stat_word[4:3]), 3);
    chk("R11", "reserved bits", int'(stat_word[STAT_W-1:5]), 0);
    cycle(1,0,0,0,0,0,0,0, "R10 word after local");
    cycle(0,0,0,0,0,1,0,0, "R10 soft reset");
    chk("R10", "mode cleared by soft reset", int'(stat_word[4:3]), 0);

    // stop state
    cycle(1,0,0,0,0,0,0,0, "R12 pre-stop word");
    cycle(1,0,0,0,0,0,0,1, "R12 stop with word");
    chk("R12", "fill in stop", int'(fill_level), 0);
    cycle(0,1,0,0,0,0,0,1, "R12 stop with read");
    cycle(1,0,0,0,0,0,0,0, "R12 after stop");

    // hardware reset mid-run with a mode set
    cycle(0,0,0,1,1,0,0,0, "R1 mode set");
    hw_reset();
    chk("R1", "irq after reset", int'(irq_req), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule